// File: doc/BRIEF.md
# Segmented Cipher-Feedback Stream Unit

This block runs a 64-bit forward block cipher in cipher-feedback fashion over a stream of short segments. The segment width s is 8, 16 or 32 bits, chosen at run time. The unit keeps a 64-bit feedback register, which is loaded from an initial value (IV). For each segment it sends the register to an external cipher engine and receives the enciphered block. It XORs the top s bits of that block with the segment. It then shifts the ciphertext segment into the low end of the register, dropping s bits from the top. Decryption uses the same forward cipher. The only difference is that the received ciphertext segment, not the XOR result, is fed back. A full 64-bit block therefore takes 8, 4 or 2 cipher calls at s = 8, 16 or 32.

Segments arrive and leave on 32-bit buses with valid/ready handshakes, right-aligned. The cipher engine sits outside the unit and is reached through a request/done handshake. The controller is a three-state machine:

- ST_IDLE waits for a segment. It leaves on an accepted input (to ST_CIPH).
- ST_CIPH holds the cipher request. It leaves when the engine reports done (to ST_HOLD).
- ST_HOLD presents the result. It returns to ST_IDLE when the consumer takes it.

While in ST_IDLE, loading an IV or selecting a different width restarts the chain. In the other two states such requests are ignored.

Top module: `cfb_seg_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE. `in_ready` is 1, `out_valid` is 0 and `ciph_req` is 0. The feedback register and the stored IV are zero, and the width is 8.
- R2: In encrypt mode (`decrypt`=0), the output segment equals the input segment XOR the most significant s bits of the cipher result for the current feedback register.
- R3: After each segment the feedback register becomes its low 64−s bits followed by the ciphertext segment. The next cipher request therefore carries that value.
- R4: In decrypt mode (`decrypt`=1), the output equals the input XOR the top s bits of the cipher result. The input segment (the ciphertext) is what gets shifted into the register. Decrypting a ciphertext stream from the same IV returns the plaintext.
- R5: `seg_sel` encodes the width as follows: 2'b00 selects 8, 2'b01 selects 16, 2'b10 selects 32, and 2'b11 acts exactly like 2'b00. A switch between 00 and 11 is therefore not a width change.
- R6: Segments are right-aligned on the 32-bit buses. Input bits at or above s are ignored, and output bits at or above s are zero.
- R7: In ST_IDLE, a cycle with `iv_load`=1 stores `iv_data` as the IV, loads it into the feedback register, and takes the width from `seg_sel`. `in_ready` is 0 in that cycle.
- R8: In ST_IDLE, a `seg_sel` whose effective width differs from the current one reloads the feedback register from the stored IV and adopts the new width. `in_ready` is 0 in that cycle.
- R9: In ST_CIPH or ST_HOLD, `seg_sel` changes and `iv_load` pulses have no effect on the segment in flight or on the chain that follows.
- R10: One cycle after an input is accepted, `ciph_req` rises with `ciph_in` equal to the feedback register. Both stay unchanged until the cycle in which `ciph_done` is seen. After that, `ciph_req` drops.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged and `in_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_sel | input | 2 | Segment width select (R5 encoding) |
| iv_load | input | 1 | Load `iv_data` as IV and restart the chain (idle only) |
| iv_data | input | 64 | Initial value for the feedback register |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt; sampled with each input segment |
| in_valid | input | 1 | Input segment valid |
| in_ready | output | 1 | Unit can accept an input segment |
| in_data | input | 32 | Input segment, right-aligned |
| out_valid | output | 1 | Output segment valid |
| out_ready | input | 1 | Consumer takes the output segment |
| out_data | output | 32 | Output segment, right-aligned, upper bits zero |
| ciph_req | output | 1 | Request to the forward cipher engine |
| ciph_in | output | 64 | Block presented to the cipher engine |
| ciph_done | input | 1 | One-cycle pulse: cipher result ready |
| ciph_out | input | 64 | Enciphered block, valid with `ciph_done` |

## Verification
A corrupted feedback register first shows up on `ciph_in`, at the very next request after the bad shift or reload. It then shows up in the corresponding output segment, no more than a few cycles after that request completes. For this reason, every cipher request is compared with a bench-side copy of the chain, not only the outputs. A wrong width or a missed restart changes the shift amount. Every later keystream segment is then wrong, so one mismatch spreads through the rest of the stream. This is exercised by width switches and by a decrypt round trip that only closes if both directions shift identically.

// File: rtl/cfb_seg_pkg.sv
package cfb_seg_pkg;

    // Effective segment width; the codes match the seg_sel encoding.
    typedef enum logic [1:0] {
        SEG8  = 2'b00,
        SEG16 = 2'b01,
        SEG32 = 2'b10
    } seg_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CIPH = 2'b01,
        ST_HOLD = 2'b10
    } cfb_state_e;

    // Code 2'b11 folds onto the 8-bit width.
    function automatic seg_mode_e decode_sel(input logic [1:0] sel);
        seg_mode_e m;
        case (sel)
            2'b01:   m = SEG16;
            2'b10:   m = SEG32;
            default: m = SEG8;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfb_seg_ctrl.sv
module cfb_seg_ctrl
    import cfb_seg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic restart,
    input  logic ciph_done,
    input  logic out_ready,
    output logic idle,
    output logic in_ready,
    output logic accept,
    output logic ciph_req,
    output logic take,
    output logic out_valid
);

    cfb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid && !restart) state_d = ST_CIPH;
            ST_CIPH: if (ciph_done)            state_d = ST_HOLD;
            ST_HOLD: if (out_ready)            state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        in_ready  = idle && !restart;
        accept    = in_ready && in_valid;
        ciph_req  = (state_q == ST_CIPH);
        take      = ciph_req && ciph_done;
        out_valid = (state_q == ST_HOLD);
    end

    // R10: the request is held until the engine answers
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ciph_req && !ciph_done) |=> ciph_req);

    // R10: the request drops once the answer has been taken
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ciph_req);

    // R11: an output is held under backpressure
    p_out_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

endmodule

// File: rtl/cfb_seg_feedback.sv
module cfb_seg_feedback
    import cfb_seg_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv_data,
    input  seg_mode_e        sel_mode,
    input  logic             take,
    input  logic [BUS_W-1:0] fb_seg,
    output logic [BLK_W-1:0] shreg,
    output seg_mode_e        mode_q,
    output logic             restart
);

    logic [BLK_W-1:0] iv_q;
    logic [BLK_W-1:0] shifted;

    assign restart = idle && (iv_load || (sel_mode != mode_q));

    // Drop the top s bits and append the feedback segment at the bottom.
    always_comb begin
        unique case (mode_q)
            SEG16:   shifted = {shreg[BLK_W-17:0], fb_seg[15:0]};
            SEG32:   shifted = {shreg[BLK_W-33:0], fb_seg[31:0]};
            default: shifted = {shreg[BLK_W-9:0],  fb_seg[7:0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q   <= '0;
            shreg  <= '0;
            mode_q <= SEG8;
        end else if (idle && iv_load) begin
            iv_q   <= iv_data;
            shreg  <= iv_data;
            mode_q <= sel_mode;
        end else if (idle && (sel_mode != mode_q)) begin
            shreg  <= iv_q;
            mode_q <= sel_mode;
        end else if (take) begin
            shreg  <= shifted;
        end
    end

    // R7: an idle IV load lands in the register
    p_iv_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && iv_load) |=> (shreg == $past(iv_data)));

    // R9: width is frozen while a segment is in flight
    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(mode_q));

    // R3: 8-bit shift keeps the old low bits on top
    p_shift8_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_q == SEG8) |=> (shreg[BLK_W-1:8] == $past(shreg[BLK_W-9:0])));

    // R3: 32-bit shift keeps the old low bits on top
    p_shift32_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_q == SEG32) |=> (shreg[BLK_W-1:32] == $past(shreg[BLK_W-33:0])));

endmodule

// File: rtl/cfb_seg_combine.sv
module cfb_seg_combine
    import cfb_seg_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int BUS_W = 32
) (
    input  seg_mode_e        mode,
    input  logic             decrypt,
    input  logic [BUS_W-1:0] seg_in,
    input  logic [BLK_W-1:0] ks_blk,
    output logic [BUS_W-1:0] result,
    output logic [BUS_W-1:0] fb_seg
);

    localparam int NW = 3;

    logic [BUS_W-1:0] res_v [NW];
    logic [BUS_W-1:0] fb_v  [NW];

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [W-1:0] ks, din, dout;
        assign ks       = ks_blk[BLK_W-1 -: W];
        assign din      = seg_in[W-1:0];
        assign dout     = din ^ ks;
        assign res_v[g] = BUS_W'(dout);
        assign fb_v[g]  = decrypt ? BUS_W'(din) : BUS_W'(dout);
    end

    always_comb begin
        unique case (mode)
            SEG16: begin
                result = res_v[1];
                fb_seg = fb_v[1];
            end
            SEG32: begin
                result = res_v[2];
                fb_seg = fb_v[2];
            end
            default: begin
                result = res_v[0];
                fb_seg = fb_v[0];
            end
        endcase
    end

endmodule

// File: rtl/cfb_seg_unit.sv
module cfb_seg_unit
    import cfb_seg_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       seg_sel,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv_data,
    input  logic             decrypt,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BUS_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BUS_W-1:0] out_data,
    output logic             ciph_req,
    output logic [BLK_W-1:0] ciph_in,
    input  logic             ciph_done,
    input  logic [BLK_W-1:0] ciph_out
);

    logic             idle, accept, take, restart;
    seg_mode_e        mode_q;
    logic [BLK_W-1:0] shreg;
    logic [BUS_W-1:0] seg_q, out_q, result, fb_seg;
    logic             dec_q;

    cfb_seg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .restart   (restart),
        .ciph_done (ciph_done),
        .out_ready (out_ready),
        .idle      (idle),
        .in_ready  (in_ready),
        .accept    (accept),
        .ciph_req  (ciph_req),
        .take      (take),
        .out_valid (out_valid)
    );

    cfb_seg_feedback #(.BLK_W(BLK_W), .BUS_W(BUS_W)) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .iv_load  (iv_load),
        .iv_data  (iv_data),
        .sel_mode (decode_sel(seg_sel)),
        .take     (take),
        .fb_seg   (fb_seg),
        .shreg    (shreg),
        .mode_q   (mode_q),
        .restart  (restart)
    );

    cfb_seg_combine #(.BLK_W(BLK_W), .BUS_W(BUS_W)) u_comb (
        .mode    (mode_q),
        .decrypt (dec_q),
        .seg_in  (seg_q),
        .ks_blk  (ciph_out),
        .result  (result),
        .fb_seg  (fb_seg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            dec_q <= 1'b0;
            out_q <= '0;
        end else begin
            if (accept) begin
                seg_q <= in_data;
                dec_q <= decrypt;
            end
            if (take) out_q <= result;
        end
    end

    assign ciph_in  = shreg;
    assign out_data = out_q;

    // R10: cipher input stays put while the request waits
    p_cin_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ciph_req && !ciph_done) |=> $stable(ciph_in));

    // R10: an accepted segment raises the request next cycle
    p_req_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ciph_req);

    // R11: held output data does not move
    p_out_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R6: an 8-bit result leaves the upper lanes zero
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == SEG8) |-> (out_data[BUS_W-1:8] == '0));

endmodule

// File: tb/cfb_seg_unit_test.sv
module cfb_seg_unit_test;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  seg_sel = 2'b00;
    logic        iv_load = 1'b0;
    logic [63:0] iv_data = '0;
    logic        decrypt = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        ciph_req;
    logic [63:0] ciph_in;
    logic        ciph_done;
    logic [63:0] ciph_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cfb_seg_unit uut (
        .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel), .iv_load(iv_load),
        .iv_data(iv_data), .decrypt(decrypt), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .ciph_req(ciph_req),
        .ciph_in(ciph_in), .ciph_done(ciph_done), .ciph_out(ciph_out)
    );

    function automatic logic [63:0] toy_cipher(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ 64'h0F1E2D3C4B5A6978;
        y = y * 64'h9E3779B97F4A7C15;
        y = {y[22:0], y[63:23]} ^ (y >> 17);
        return y ^ 64'hC3A55A3C12348765;
    endfunction

    // Cipher engine model
    int lat_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt   <= 0;
            ciph_done <= 1'b0;
            ciph_out  <= '0;
        end else begin
            ciph_done <= 1'b0;
            if (ciph_req && !ciph_done) begin
                if (lat_cnt == LAT) begin
                    ciph_done <= 1'b1;
                    ciph_out  <= toy_cipher(ciph_in);
                    lat_cnt   <= 0;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    // Reference chain
    logic [63:0] ref_iv  = '0;
    logic [63:0] ref_reg = '0;
    int          ref_w   = 8;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] cin_q[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic int eff_w(input logic [1:0] s);
        return (s == 2'b01) ? 16 : (s == 2'b10) ? 32 : 8;
    endfunction

    // Scoreboard monitor
    bit req_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ciph_req && !req_seen) begin
                if (cin_q.size() == 0) check(0, "R10 unexpected request", ciph_in, 0);
                else begin
                    logic [63:0] e;
                    e = cin_q.pop_front();
                    check(ciph_in == e, "R3/R10 cipher input", ciph_in, e);
                end
            end
            req_seen = ciph_req;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check(0, "R2 unexpected output", {32'b0, out_data}, 0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, {32'b0, out_data}, {32'b0, e});
                end
            end
        end
    end

    // Driver: computes expected output, then offers the segment
    task automatic send(input logic [31:0] d, input bit dec, input string tag,
                        output logic [31:0] res);
        logic [31:0] mask, dm, ks, c;
        logic [63:0] blk;
        mask = (ref_w == 32) ? 32'hFFFF_FFFF : ((32'h1 << ref_w) - 1);
        dm   = d & mask;
        blk  = toy_cipher(ref_reg);
        ks   = 32'(blk >> (64 - ref_w));
        res  = (dm ^ ks) & mask;
        c    = dec ? dm : res;
        exp_q.push_back(res);
        tag_q.push_back(tag);
        cin_q.push_back(ref_reg);
        ref_reg = (ref_reg << ref_w) | 64'(c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        decrypt  = dec;
        #1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_iv(input logic [63:0] v);
        @(negedge clk);
        iv_load = 1'b1;
        iv_data = v;
        #1;
        check(in_ready == 1'b0, "R7 in_ready low during load", {63'b0, in_ready}, 0);
        @(negedge clk);
        iv_load = 1'b0;
        ref_iv  = v;
        ref_reg = v;
        ref_w   = eff_w(seg_sel);
    endtask

    task automatic set_sel(input logic [1:0] s);
        @(negedge clk);
        seg_sel = s;
        #1;
        if (eff_w(s) != ref_w) begin
            check(in_ready == 1'b0, "R8 restart cycle", {63'b0, in_ready}, 0);
            ref_reg = ref_iv;
            ref_w   = eff_w(s);
        end else begin
            check(in_ready == 1'b1, "R5 code 11 equals 00, no restart", {63'b0, in_ready}, 1);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] pt [6];
        logic [31:0] ct [6];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1,  "R1 in_ready", {63'b0, in_ready}, 1);
        check(out_valid == 1'b0, "R1 out_valid", {63'b0, out_valid}, 0);
        check(ciph_req == 1'b0,  "R1 ciph_req", {63'b0, ciph_req}, 0);
        check(ciph_in == 64'b0,  "R1 register zero", ciph_in, 0);

        // R2, R3 at 8-bit width, including upper garbage (R6)
        load_iv(64'h0123_4567_89AB_CDEF);
        send(32'h0000_005A, 0, "R2 enc s8", r);
        send(32'hFFFF_FF11, 0, "R6 upper input ignored s8", r);
        for (int i = 0; i < 8; i++) send(32'(i * 37 + 3), 0, "R3 chain s8", r);
        drain();

        // R8 width change to 16 restarts from IV
        set_sel(2'b01);
        for (int i = 0; i < 5; i++) send(32'hABCD_0000 + 32'(i * 4099), 0, "R8 restart s16", r);
        drain();

        // R5/R8 width 32
        set_sel(2'b10);
        for (int i = 0; i < 3; i++) send(32'hDEAD_BEEF ^ 32'(i), 0, "R5 s32", r);
        drain();

        // R5 code 11 behaves as 8; 00 <-> 11 is no restart
        set_sel(2'b00);
        send(32'h0000_0042, 0, "R5 sel00", r);
        drain();
        set_sel(2'b11);
        send(32'h0000_0099, 0, "R5 sel11 continues chain", r);
        drain();

        // R4 decrypt round trip at 16 bits
        set_sel(2'b01);
        load_iv(64'hFEED_FACE_CAFE_F00D);
        for (int i = 0; i < 6; i++) begin
            pt[i] = 32'(16'h1111 * (i + 1));
            send(pt[i], 0, "R4 encrypt leg", ct[i]);
        end
        drain();
        load_iv(64'hFEED_FACE_CAFE_F00D);
        for (int i = 0; i < 6; i++) begin
            send(ct[i], 1, "R4 decrypt leg", r);
            check(r == pt[i], "R4 model round trip", {32'b0, r}, {32'b0, pt[i]});
        end
        drain();

        // R11 backpressure
        out_ready = 1'b0;
        send(32'h0000_1234, 0, "R11 held result", r);
        while (!out_valid) @(negedge clk);
        begin
            logic [31:0] held;
            held = out_data;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(out_valid && out_data == held && !in_ready,
                      "R11 hold under backpressure", {32'b0, out_data}, {32'b0, held});
            end
        end
        out_ready = 1'b1;
        drain();

        // R9 mid-stream width change and IV load are ignored
        out_ready = 1'b0;
        send(32'h0000_7777, 0, "R9 segment in flight", r);
        seg_sel = 2'b10;
        iv_load = 1'b1;
        iv_data = 64'h5555_AAAA_5555_AAAA;
        @(negedge clk);
        iv_load = 1'b0;
        while (!out_valid) @(negedge clk);
        seg_sel = 2'b01;
        @(negedge clk);
        out_ready = 1'b1;
        drain();
        send(32'h0000_3C3C, 0, "R9 chain continues", r);
        send(32'h0000_0F0F, 1, "R9 decrypt after", r);
        drain();

        check(exp_q.size() == 0, "R2 scoreboard empty", 64'(exp_q.size()), 0);
        finish_run();
    end

endmodule